// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is a self-test function placed behind a bus endpoint. The host programs it through a small word-addressed register port. There are registers for a magic word, a command, a result status, a source buffer address, a destination buffer address, a byte count, a checksum, an interrupt kind and an interrupt vector. Writing the command register starts one operation. The operation is either a plain interrupt request or a transfer against host memory: the block reads host memory, writes host memory, or copies from one host buffer to another. The transfers go through a word-wide request/acknowledge memory master.

Every transfer folds the words it moves into a 32-bit XOR checksum. A read is judged against the checksum the host placed in the checksum register. A write leaves its checksum in that register for the host to check. Before any memory is touched, both buffer addresses are validated. Each operation ends by setting its own pass or fail bit in the status register and pulsing a completion interrupt request towards the interrupt dispatcher.

Top module: `ep_test_engine`

## Requirements
- R1: The magic register (word 0) reads back exactly the last value written to it; it is 0 after reset.
- R2: Registers sit at word indices 0 magic, 1 command, 2 status, 3 source address, 4 destination address, 5 byte count, 6 checksum, 7 interrupt kind (2 bits), 8 interrupt vector; the status register is read-only, and host writes to it have no effect.
- R3: Command bits: 0 legacy interrupt, 1 MSI, 2 MSI-X, 3 read, 4 write, 5 copy. When several bits are set, a transfer wins over an interrupt request: read first, then write, then copy. Among the interrupt bits, bit 0 has the highest priority, then bit 1, then bit 2.
- R4: Status bits: 0 read pass, 1 read fail, 2 write pass, 3 write fail, 4 copy pass, 5 copy fail, 6 interrupt raised, 7 bad source, 8 bad destination. An accepted command write clears bits 0 to 8 before the operation runs. At most one of bits 0 to 5 is set after an operation.
- R5: A read fetches count/4 words, one at a time, from ascending addresses starting at the source address. It passes exactly when the XOR of those words equals the checksum register.
- R6: A write stores word PATTERN_BASE+k (default 32'hC0DE_0000+k) at destination+4k for k = 0 .. count/4-1. It then loads the XOR of the written words into the checksum register. With a count of 0, no access is made and the checksum becomes 0.
- R7: A copy moves count/4 words from source to destination. It reads one word and then writes that word, word by word, so the accesses alternate read, write, read, write.
- R8: An address is bad when bits [1:0] are not 0 or when address+count exceeds 2^32. A buffer that ends exactly at 2^32 is valid. A bad address that the operation uses sets its bad bit (7 or 8) and the operation's fail bit, and no memory access is made.
- R9: Every operation ends with a one-cycle irq_req and sets status bit 6. irq_num carries the vector register. For transfers, irq_kind carries the interrupt kind register. For an interrupt command, irq_kind is 0, 1 or 2 for legacy, MSI or MSI-X.
- R10: A command write while an operation is in progress is ignored: it starts nothing and clears no status.
- R11: Only one memory access is outstanding at a time. mem_req, mem_we and mem_addr hold steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq_req | output | 1 | One-cycle completion interrupt request |
| irq_kind | output | 2 | 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | 12 | Interrupt vector |

## Verification
The bench targets the validation edges. It uses a buffer that ends exactly at 2^32, one that crosses it, and a misaligned one. A design with an off-by-one wrap test would reject the first buffer or accept the second, and a missed check would show up as memory accesses counted on a bad command. The memory model stretches acknowledges over several cycles. A sequencer that moves on early or changes its address mid-access would leave wrong data or break the read/write alternation of a copy. Command bit combinations and a command written while busy expose wrong priority or a second run, which shows as extra accesses, a second interrupt or a cleared status.

// File: rtl/ept_pkg.sv
package ept_pkg;
   typedef enum logic [2:0] {OP_NONE, OP_READ, OP_WRITE, OP_COPY, OP_IRQ} op_e;
   typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_WR, S_FIN} st_e;

   localparam logic [3:0] W_MAGIC  = 4'd0;
   localparam logic [3:0] W_CMD    = 4'd1;
   localparam logic [3:0] W_STAT   = 4'd2;
   localparam logic [3:0] W_SRC    = 4'd3;
   localparam logic [3:0] W_DST    = 4'd4;
   localparam logic [3:0] W_SIZE   = 4'd5;
   localparam logic [3:0] W_CSUM   = 4'd6;
   localparam logic [3:0] W_IKIND  = 4'd7;
   localparam logic [3:0] W_IVEC   = 4'd8;

   localparam int B_RD_OK  = 0;
   localparam int B_RD_BAD = 1;
   localparam int B_WR_OK  = 2;
   localparam int B_WR_BAD = 3;
   localparam int B_CP_OK  = 4;
   localparam int B_CP_BAD = 5;
   localparam int B_IRQ    = 6;
   localparam int B_SRC_X  = 7;
   localparam int B_DST_X  = 8;
   localparam int STAT_W   = 9;
endpackage

// File: rtl/ept_addr_check.sv
module ept_addr_check #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] size_i,
   output logic          ok_o
);
   logic [AW:0] fin;
   assign fin  = {1'b0, addr_i} + {1'b0, size_i};
   // ending exactly at 2^AW is allowed; anything past it wraps
   assign ok_o = (addr_i[1:0] == 2'b00) && !(fin[AW] && (fin[AW-1:0] != '0));
endmodule

// File: rtl/ept_cmd_decode.sv
module ept_cmd_decode
   import ept_pkg::*;
(
   input  logic [5:0] cmd_i,
   output op_e        op_o,
   output logic [1:0] kind_o
);
   always_comb begin
      op_o   = OP_NONE;
      kind_o = 2'd0;
      if (cmd_i[3])      op_o = OP_READ;
      else if (cmd_i[4]) op_o = OP_WRITE;
      else if (cmd_i[5]) op_o = OP_COPY;
      else if (cmd_i[0]) begin op_o = OP_IRQ; kind_o = 2'd0; end
      else if (cmd_i[1]) begin op_o = OP_IRQ; kind_o = 2'd1; end
      else if (cmd_i[2]) begin op_o = OP_IRQ; kind_o = 2'd2; end
   end
endmodule

// File: rtl/ept_xfer_seq.sv
module ept_xfer_seq
   import ept_pkg::*;
#(
   parameter int          AW           = 32,
   parameter logic [31:0] PATTERN_BASE = 32'hC0DE_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  op_e           op_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [AW-1:0] size_i,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [AW-1:0] mem_rdata,
   output logic          busy_o,
   output logic          done_o,
   output op_e           op_o,
   output logic          ok_o,
   output logic          src_bad_o,
   output logic          dst_bad_o,
   output logic [AW-1:0] csum_o
);
   localparam int NW = AW - 2;

   st_e           st;
   op_e           op_q;
   logic [AW-1:0] rp, wp, size_q, cnt, data_q, acc;
   logic [NW-1:0] nleft;
   logic          sbad, dbad, ok_q;
   logic          need_src, need_dst, sb_now, db_now;
   logic [1:0]    chk_ok;
   logic [AW-1:0] chk_addr [2];

   assign chk_addr[0] = rp;
   assign chk_addr[1] = wp;

   for (genvar g = 0; g < 2; g++) begin : g_chk
      ept_addr_check #(.AW(AW)) u_chk (
         .addr_i(chk_addr[g]),
         .size_i(size_q),
         .ok_o  (chk_ok[g])
      );
   end

   assign need_src = (op_q == OP_READ)  || (op_q == OP_COPY);
   assign need_dst = (op_q == OP_WRITE) || (op_q == OP_COPY);
   assign sb_now   = need_src && !chk_ok[0];
   assign db_now   = need_dst && !chk_ok[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         op_q   <= OP_NONE;
         rp     <= '0;
         wp     <= '0;
         size_q <= '0;
         cnt    <= '0;
         data_q <= '0;
         acc    <= '0;
         nleft  <= '0;
         sbad   <= 1'b0;
         dbad   <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (start_i && op_i != OP_NONE) begin
               op_q   <= op_i;
               rp     <= src_i;
               wp     <= dst_i;
               size_q <= size_i;
               nleft  <= size_i[AW-1:2];
               cnt    <= '0;
               acc    <= '0;
               sbad   <= 1'b0;
               dbad   <= 1'b0;
               ok_q   <= 1'b1;
               st     <= (op_i == OP_IRQ) ? S_FIN : S_CHECK;
            end
            S_CHECK: begin
               sbad <= sb_now;
               dbad <= db_now;
               if (sb_now || db_now) begin
                  ok_q <= 1'b0;
                  st   <= S_FIN;
               end else if (nleft == '0) begin
                  st <= S_FIN;
               end else begin
                  st <= (op_q == OP_WRITE) ? S_WR : S_RD;
               end
            end
            S_RD: if (mem_ack) begin
               acc    <= acc ^ mem_rdata;
               data_q <= mem_rdata;
               rp     <= rp + AW'(4);
               if (op_q == OP_COPY) begin
                  st <= S_WR;
               end else begin
                  nleft <= nleft - NW'(1);
                  if (nleft == NW'(1)) st <= S_FIN;
               end
            end
            S_WR: if (mem_ack) begin
               if (op_q == OP_WRITE) acc <= acc ^ mem_wdata;
               wp    <= wp + AW'(4);
               cnt   <= cnt + AW'(1);
               nleft <= nleft - NW'(1);
               if (nleft == NW'(1))       st <= S_FIN;
               else if (op_q == OP_COPY)  st <= S_RD;
            end
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign mem_req   = (st == S_RD) || (st == S_WR);
   assign mem_we    = (st == S_WR);
   assign mem_addr  = (st == S_WR) ? wp : rp;
   assign mem_wdata = (op_q == OP_COPY) ? data_q : (PATTERN_BASE + cnt);
   assign busy_o    = (st != S_IDLE);
   assign done_o    = (st == S_FIN);
   assign op_o      = op_q;
   assign ok_o      = ok_q;
   assign src_bad_o = sbad;
   assign dst_bad_o = dbad;
   assign csum_o    = acc;

   // R11: an access is held unchanged until acknowledged
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R8: a failed validation never reaches memory
   p_bad_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CHECK && (sb_now || db_now)) |=> !mem_req);
   // R6: a read operation never writes
   p_read_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (op_q != OP_READ));
   // R7: in a copy each completed read is followed by a write
   p_copy_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RD && mem_ack && op_q == OP_COPY) |=> (mem_req && mem_we));
endmodule

// File: rtl/ep_test_engine.sv
module ep_test_engine
   import ept_pkg::*;
#(
   parameter int          AW           = 32,
   parameter int          IRQN_W       = 12,
   parameter logic [31:0] PATTERN_BASE = 32'hC0DE_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_word,
   input  logic [AW-1:0]     reg_wdata,
   output logic [AW-1:0]     reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [AW-1:0]     mem_wdata,
   input  logic              mem_ack,
   input  logic [AW-1:0]     mem_rdata,
   output logic              irq_req,
   output logic [1:0]        irq_kind,
   output logic [IRQN_W-1:0] irq_num
);
   if (AW != 32) begin : g_bad_aw
      $error("ep_test_engine: AW must be 32");
   end
   if (IRQN_W < 1 || IRQN_W > AW) begin : g_bad_irqn
      $error("ep_test_engine: IRQN_W out of range");
   end

   logic [AW-1:0]     magic_q, src_q, dst_q, size_q, csum_q;
   logic [5:0]        cmd_q;
   logic [STAT_W-1:0] stat_q;
   logic [1:0]        ikind_q, rkind_q;
   logic [IRQN_W-1:0] ivec_q;

   op_e           dec_op, seq_op;
   logic [1:0]    dec_kind;
   logic          busy, done, seq_ok, sbad, dbad, cmd_hit, fire, rd_pass;
   logic [AW-1:0] seq_csum;

   assign cmd_hit = reg_we && (reg_word == W_CMD);
   assign fire    = cmd_hit && !busy;

   ept_cmd_decode u_dec (
      .cmd_i (reg_wdata[5:0]),
      .op_o  (dec_op),
      .kind_o(dec_kind)
   );

   ept_xfer_seq #(.AW(AW), .PATTERN_BASE(PATTERN_BASE)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (fire),
      .op_i     (dec_op),
      .src_i    (src_q),
      .dst_i    (dst_q),
      .size_i   (size_q),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_ack  (mem_ack),
      .mem_rdata(mem_rdata),
      .busy_o   (busy),
      .done_o   (done),
      .op_o     (seq_op),
      .ok_o     (seq_ok),
      .src_bad_o(sbad),
      .dst_bad_o(dbad),
      .csum_o   (seq_csum)
   );

   assign rd_pass = seq_ok && (seq_csum == csum_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         magic_q  <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         size_q   <= '0;
         csum_q   <= '0;
         cmd_q    <= '0;
         stat_q   <= '0;
         ikind_q  <= '0;
         rkind_q  <= '0;
         ivec_q   <= '0;
         irq_req  <= 1'b0;
         irq_kind <= '0;
         irq_num  <= '0;
      end else begin
         irq_req <= 1'b0;
         if (reg_we) begin
            case (reg_word)
               W_MAGIC: magic_q <= reg_wdata;
               W_SRC:   src_q   <= reg_wdata;
               W_DST:   dst_q   <= reg_wdata;
               W_SIZE:  size_q  <= reg_wdata;
               W_CSUM:  csum_q  <= reg_wdata;
               W_IKIND: ikind_q <= reg_wdata[1:0];
               W_IVEC:  ivec_q  <= reg_wdata[IRQN_W-1:0];
               default: ;
            endcase
         end
         if (fire) begin
            cmd_q   <= reg_wdata[5:0];
            rkind_q <= dec_kind;
            stat_q  <= '0;
         end
         if (done) begin
            case (seq_op)
               OP_READ: begin
                  stat_q[B_RD_OK]  <= rd_pass;
                  stat_q[B_RD_BAD] <= !rd_pass;
                  stat_q[B_SRC_X]  <= sbad;
               end
               OP_WRITE: begin
                  stat_q[B_WR_OK]  <= seq_ok;
                  stat_q[B_WR_BAD] <= !seq_ok;
                  stat_q[B_DST_X]  <= dbad;
                  if (seq_ok) csum_q <= seq_csum;
               end
               OP_COPY: begin
                  stat_q[B_CP_OK]  <= seq_ok;
                  stat_q[B_CP_BAD] <= !seq_ok;
                  stat_q[B_SRC_X]  <= sbad;
                  stat_q[B_DST_X]  <= dbad;
               end
               default: ;
            endcase
            stat_q[B_IRQ] <= 1'b1;
            irq_req       <= 1'b1;
            irq_kind      <= (seq_op == OP_IRQ) ? rkind_q : ikind_q;
            irq_num       <= ivec_q;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_word)
         W_MAGIC: reg_rdata = magic_q;
         W_CMD:   reg_rdata = AW'(cmd_q);
         W_STAT:  reg_rdata = AW'(stat_q);
         W_SRC:   reg_rdata = src_q;
         W_DST:   reg_rdata = dst_q;
         W_SIZE:  reg_rdata = size_q;
         W_CSUM:  reg_rdata = csum_q;
         W_IKIND: reg_rdata = AW'(ikind_q);
         W_IVEC:  reg_rdata = AW'(ivec_q);
         default: reg_rdata = '0;
      endcase
   end

   // R9: completion request lasts exactly one cycle
   p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);
   // R10: a command written while busy leaves status untouched
   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && cmd_hit) |=> (stat_q == $past(stat_q)));
   // R4: one outcome bit at most per operation
   p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ($countones(stat_q[5:0]) <= 1));
   // R9: the raised bit accompanies every completion
   p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> stat_q[B_IRQ]);
endmodule

// File: tb/ep_test_engine_bench.sv
module ep_test_engine_bench;
   localparam logic [31:0] PAT = 32'hC0DE_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_word = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        irq_req;
   logic [1:0]  irq_kind;
   logic [11:0] irq_num;

   always #5 clk = ~clk;

   ep_test_engine u_ep_test_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_req(irq_req),
      .irq_kind(irq_kind), .irq_num(irq_num)
   );

   // host memory model with programmable acknowledge latency
   logic [31:0] mem [256];
   logic        ack_r = 1'b0, pend = 1'b0, pwe = 1'b0;
   logic [31:0] rd_r = '0, paddr = '0;
   int          wcnt = 0, lat = 1, nacc = 0, nirq = 0, hold_err = 0;
   logic        ord [64];
   logic        bd_we = 1'b0;
   logic [7:0]  bd_idx = '0;
   logic [31:0] bd_data = '0;

   assign mem_ack   = ack_r;
   assign mem_rdata = rd_r;

   always @(posedge clk) begin
      ack_r <= 1'b0;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= '0;
         pend <= 1'b0;
      end else begin
         if (bd_we) mem[bd_idx] <= bd_data;
         if (irq_req) nirq <= nirq + 1;
         if (mem_req && !ack_r) begin
            if (!pend) begin
               pend <= 1'b1; paddr <= mem_addr; pwe <= mem_we; wcnt <= 0;
            end else begin
               if (mem_addr != paddr || mem_we != pwe) hold_err <= hold_err + 1;
               if (wcnt >= lat) begin
                  ack_r <= 1'b1;
                  pend  <= 1'b0;
                  if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                  else        rd_r <= mem[mem_addr[9:2]];
                  ord[nacc % 64] <= mem_we;
                  nacc <= nacc + 1;
               end else begin
                  wcnt <= wcnt + 1;
               end
            end
         end
      end
   end

   int total = 0, fails = 0;
   logic [1:0]  g_kind;
   logic [11:0] g_num;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ceq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic reg_wr(input logic [3:0] w, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_word = w; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] w, output logic [31:0] d);
      @(negedge clk);
      reg_word = w;
      #1 d = reg_rdata;
   endtask

   task automatic poke(input logic [7:0] idx, input logic [31:0] d);
      @(negedge clk);
      bd_we = 1'b1; bd_idx = idx; bd_data = d;
      @(negedge clk);
      bd_we = 1'b0;
   endtask

   task automatic wait_irq(input string tag);
      bit got = 0;
      for (int i = 0; i < 3000 && !got; i++) begin
         @(negedge clk);
         if (irq_req) begin got = 1; g_kind = irq_kind; g_num = irq_num; end
      end
      chk(got, {tag, " completion irq"}, 32'(got), 32'd1);
   endtask

   task automatic run(input logic [31:0] cmd, input string tag);
      reg_wr(4'd1, cmd);
      wait_irq(tag);
   endtask

   function automatic logic [31:0] sval(input int k);
      return 32'h1000_0001 * (k + 3);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      reg_rd(4'd2, d); ceq("R4 status after reset", d, 32'h0);
      reg_rd(4'd0, d); ceq("R1 magic after reset", d, 32'h0);
      ceq("R9 irq idle after reset", 32'(irq_req), 32'd0);
      ceq("R11 no request after reset", 32'(mem_req), 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      reg_wr(4'd0, 32'hDEAD_BEEF); reg_rd(4'd0, d); ceq("R1 magic readback", d, 32'hDEAD_BEEF);
      reg_wr(4'd0, 32'h0123_4567); reg_rd(4'd0, d); ceq("R1 magic second", d, 32'h0123_4567);
      reg_wr(4'd2, 32'h1FF);       reg_rd(4'd2, d); ceq("R2 status read-only", d, 32'h0);
      reg_wr(4'd5, 32'h0000_0ABC); reg_rd(4'd5, d); ceq("R2 count at word 5", d, 32'h0000_0ABC);
   endtask

   task automatic t_read();
      logic [31:0] d, x = '0; int n0;
      for (int k = 0; k < 4; k++) begin poke(8'h10 + 8'(k), sval(k)); x ^= sval(k); end
      reg_wr(4'd3, 32'h40); reg_wr(4'd5, 32'd16);
      reg_wr(4'd7, 32'd1);  reg_wr(4'd8, 32'd7); reg_wr(4'd6, x);
      n0 = nacc;
      run(32'h08, "R5 read");
      reg_rd(4'd2, d); ceq("R5 read pass status", d, 32'h41);
      ceq("R5 read word count", 32'(nacc - n0), 32'd4);
      ceq("R9 kind from register", 32'(g_kind), 32'd1);
      ceq("R9 vector", 32'(g_num), 32'd7);
      reg_wr(4'd6, x ^ 32'h1);
      run(32'h08, "R5 read mismatch");
      reg_rd(4'd2, d); ceq("R5 read fail status", d, 32'h42);
   endtask

   task automatic t_write();
      logic [31:0] d, x = '0;
      reg_wr(4'd4, 32'h200); reg_wr(4'd5, 32'd16); reg_wr(4'd7, 32'd2);
      run(32'h10, "R6 write");
      reg_rd(4'd2, d); ceq("R6 write pass status", d, 32'h44);
      ceq("R9 MSI-X kind", 32'(g_kind), 32'd2);
      for (int k = 0; k < 4; k++) begin
         ceq("R6 written word", mem[8'h80 + 8'(k)], PAT + 32'(k));
         x ^= PAT + 32'(k);
      end
      reg_rd(4'd6, d); ceq("R6 stored checksum", d, x);
   endtask

   task automatic t_copy();
      logic [31:0] d; int n0;
      lat = 3;
      reg_wr(4'd3, 32'h40); reg_wr(4'd4, 32'h300); reg_wr(4'd5, 32'd12);
      n0 = nacc;
      run(32'h20, "R7 copy");
      reg_rd(4'd2, d); ceq("R7 copy pass status", d, 32'h50);
      for (int k = 0; k < 3; k++) ceq("R7 copied word", mem[8'hC0 + 8'(k)], sval(k));
      ceq("R7 access count", 32'(nacc - n0), 32'd6);
      for (int j = 0; j < 6; j++)
         ceq("R7 alternating order", 32'(ord[(n0 + j) % 64]), 32'(j % 2));
      ceq("R11 held until ack", 32'(hold_err), 32'd0);
      lat = 1;
   endtask

   task automatic t_bad();
      logic [31:0] d; int n0;
      n0 = nacc;
      reg_wr(4'd3, 32'h42); reg_wr(4'd5, 32'd16); reg_wr(4'd7, 32'd0);
      run(32'h08, "R8 misaligned source");
      reg_rd(4'd2, d); ceq("R8 misaligned read status", d, 32'hC2);
      reg_wr(4'd3, 32'h40); reg_wr(4'd4, 32'hFFFF_FFF8);
      run(32'h20, "R8 wrapping destination");
      reg_rd(4'd2, d); ceq("R8 wrap copy status", d, 32'h160);
      reg_wr(4'd4, 32'h201);
      run(32'h10, "R8 misaligned destination");
      reg_rd(4'd2, d); ceq("R8 misaligned write status", d, 32'h148);
      ceq("R8 no memory access", 32'(nacc - n0), 32'd0);
   endtask

   task automatic t_edge();
      logic [31:0] d, x = '0;
      for (int k = 0; k < 4; k++) begin poke(8'hFC + 8'(k), sval(k + 9)); x ^= sval(k + 9); end
      reg_wr(4'd3, 32'hFFFF_FFF0); reg_wr(4'd5, 32'd16); reg_wr(4'd6, x);
      run(32'h08, "R8 end at 2^32");
      reg_rd(4'd2, d); ceq("R8 buffer ending at 2^32 valid", d, 32'h41);
   endtask

   task automatic t_raise();
      logic [31:0] d; int n0;
      n0 = nacc;
      reg_wr(4'd8, 32'd33);
      run(32'h02, "R9 MSI");
      ceq("R9 MSI kind", 32'(g_kind), 32'd1);
      ceq("R9 MSI vector", 32'(g_num), 32'd33);
      reg_rd(4'd2, d); ceq("R9 raise status", d, 32'h40);
      run(32'h04, "R9 MSI-X");
      ceq("R9 MSI-X command kind", 32'(g_kind), 32'd2);
      run(32'h06, "R3 interrupt priority");
      ceq("R3 MSI over MSI-X", 32'(g_kind), 32'd1);
      reg_wr(4'd7, 32'd2);
      run(32'h03, "R3 legacy first");
      ceq("R3 legacy over MSI", 32'(g_kind), 32'd0);
      ceq("R9 raise makes no access", 32'(nacc - n0), 32'd0);
   endtask

   task automatic t_prio();
      logic [31:0] d, x = '0; int n0;
      for (int k = 0; k < 4; k++) x ^= sval(k);
      reg_wr(4'd3, 32'h40); reg_wr(4'd4, 32'h380); reg_wr(4'd5, 32'd16); reg_wr(4'd6, x);
      n0 = nacc;
      run(32'h39, "R3 transfer priority");
      reg_rd(4'd2, d); ceq("R3 read wins", d, 32'h41);
      ceq("R3 only reads", 32'(nacc - n0), 32'd4);
      ceq("R3 transfer irq kind", 32'(g_kind), 32'd2);
      ceq("R3 destination untouched", mem[8'hE0], 32'h0);
   endtask

   task automatic t_busy();
      logic [31:0] d, x = '0; int n0, i0;
      lat = 2;
      for (int k = 4; k < 8; k++) poke(8'h10 + 8'(k), sval(k));
      for (int k = 0; k < 8; k++) x ^= sval(k);
      reg_wr(4'd3, 32'h40); reg_wr(4'd4, 32'h380); reg_wr(4'd5, 32'd32); reg_wr(4'd6, x);
      n0 = nacc; i0 = nirq;
      reg_wr(4'd1, 32'h08);
      reg_rd(4'd2, d); ceq("R4 status cleared on command", d, 32'h0);
      reg_wr(4'd1, 32'h10);
      wait_irq("R10 busy");
      repeat (40) @(negedge clk);
      reg_rd(4'd2, d); ceq("R10 first command result kept", d, 32'h41);
      ceq("R10 no second run", 32'(nacc - n0), 32'd8);
      ceq("R10 single interrupt", 32'(nirq - i0), 32'd1);
      ceq("R10 no write issued", mem[8'hE0], 32'h0);
      lat = 1;
   endtask

   task automatic t_zero();
      logic [31:0] d; int n0;
      n0 = nacc;
      reg_wr(4'd4, 32'h200); reg_wr(4'd5, 32'd0);
      run(32'h10, "R6 empty write");
      reg_rd(4'd2, d); ceq("R6 empty write status", d, 32'h44);
      reg_rd(4'd6, d); ceq("R6 empty checksum", d, 32'h0);
      ceq("R6 empty no access", 32'(nacc - n0), 32'd0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_read();
      t_write();
      t_copy();
      t_bad();
      t_edge();
      t_raise();
      t_prio();
      t_busy();
      t_zero();
      finish_run();
   end
endmodule